// File: doc/BRIEF.md
# Synchronisation and Power-Down Sequencer

This block is the control state machine that sits between an active-low synchronisation/power-down pin and the converter core of an oversampling ADC. Running on the master clock, it passes the pin through a synchroniser and powers the core down while the pin is held low. When the pin is released, it runs a fixed wake-up order on successive rising edges: core power-up, filter clear, and then the first new sample. Every device that receives the same low pulse therefore starts sampling on the same clock edge.

The active-low data-ready output goes high (invalid) as soon as power-down is taken. It stays high until a settling interval, counted in master-clock cycles from the filter-clear edge, has elapsed. The interval is the product of two parameters: the decimation ratio and the filter settling length in output-rate periods. A single low pulse, the usual way to clear the filter after power-up, restarts the whole order from any state. This includes the middle of settling.

Top module: `sync_pd_sequencer`

## Requirements
- R1: While rst_n is low, and on the first edge after it is released with the synchronised pin low, core_en is 0, filt_clr is 0, samp_start is 0 and rdy_n is 1. Reset asserts asynchronously.
- R2: The pin passes through SYNC_STAGES (default 2) flip-flops. A low level on sync_pd_n driven before rising edge k is acted on at edge k+SYNC_STAGES. At that edge core_en goes to 0 and rdy_n goes to 1 from any state. At edge k+SYNC_STAGES-1 the outputs are still unchanged.
- R3: While the pin stays low, the block remains powered down: core_en is 0, rdy_n is 1, and filt_clr and samp_start stay 0.
- R4: A release (high level) driven before edge k raises core_en at edge k+SYNC_STAGES, and not earlier.
- R5: On the rising edge after core_en rises, filt_clr is 1 for exactly one cycle.
- R6: On the rising edge after the filt_clr pulse, samp_start is 1 for exactly one cycle.
- R7: rdy_n falls exactly SETTLE_CYCLES = DECIM*SETTLE_ODR rising edges after the edge that raised filt_clr. It is 1 at all edges before that. SETTLE_CYCLES must be at least 3.
- R8: Once rdy_n is low and the pin stays high, rdy_n stays low, core_en stays 1, and no further filt_clr or samp_start pulses occur.
- R9: A low pulse on the pin that lasts one clock period, arriving during settling, drops core_en for one cycle. It then reruns R5 to R7 with a fresh settling count measured from the new filt_clr edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all actions on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the driver |
| sync_pd_n | input | 1 | Asynchronous active-low sync/power-down pin |
| core_en | output | 1 | Converter core enable, 0 when powered down |
| filt_clr | output | 1 | One-cycle decimation-filter clear pulse |
| samp_start | output | 1 | One-cycle marker for the first new sample |
| rdy_n | output | 1 | Active-low data-ready; 1 while output data is invalid |

## Verification
A change on the pin is due at the outputs SYNC_STAGES rising edges later. filt_clr follows one edge after core_en rises, samp_start one edge after that, and rdy_n SETTLE_CYCLES edges after filt_clr. Each stimulus vector drives the pin on a falling edge, waits an exact number of rising edges and samples on the following falling edge. The table places checks both on the due edge and one edge before it, so a change that comes a cycle early or late is caught. The short mid-settling pulse is timed so that the power-down and power-up edges fall on consecutive cycles, and the restarted settling interval is checked on both sides of its end.

// File: rtl/sync_pd_pkg.sv
package sync_pd_pkg;

  typedef enum logic [2:0] {
    ST_PDN    = 3'd0,
    ST_WAKE   = 3'd1,
    ST_FCLR   = 3'd2,
    ST_SAMP   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RUN    = 3'd5
  } seq_state_e;

endpackage

// File: rtl/sync_pd_sync.sv
module sync_pd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sync_pd_settle.sv
module sync_pd_settle #(
  parameter int unsigned LIMIT = 592,
  parameter int unsigned CW    = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic done
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (count_en) cnt_d = cnt_q + 1'b1;
    else          cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = count_en && (cnt_q == LAST);

  // Counting never wraps past the settling limit while enabled
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !done) |=> (cnt_q != '0)); // R7

endmodule

// File: rtl/sync_pd_fsm.sv
module sync_pd_fsm
  import sync_pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic settle_done,
  output logic count_en,
  output logic core_en,
  output logic filt_clr,
  output logic samp_start,
  output logic rdy_n
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!pin_lvl) begin
      state_d = ST_PDN;
    end else begin
      unique case (state_q)
        ST_PDN:    state_d = ST_WAKE;
        ST_WAKE:   state_d = ST_FCLR;
        ST_FCLR:   state_d = ST_SAMP;
        ST_SAMP:   state_d = ST_SETTLE;
        ST_SETTLE: state_d = settle_done ? ST_RUN : ST_SETTLE;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_PDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PDN;
    else        state_q <= state_d;
  end

  always_comb begin
    core_en    = (state_q != ST_PDN);
    filt_clr   = (state_q == ST_FCLR);
    samp_start = (state_q == ST_SAMP);
    rdy_n      = (state_q != ST_RUN);
    count_en   = (state_q == ST_FCLR) || (state_q == ST_SAMP) ||
                 (state_q == ST_SETTLE);
  end

  AST_PD_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_lvl |=> (!core_en && rdy_n && !filt_clr && !samp_start)); // R2

  AST_UP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && pin_lvl) |=> core_en); // R4

  AST_CLR_AFTER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_en) && pin_lvl) |=> (filt_clr && !samp_start)); // R5

  AST_SAMP_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_clr && pin_lvl) |=> (samp_start && !filt_clr)); // R6

  AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && pin_lvl) |=> (!rdy_n && core_en)); // R8

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({filt_clr, samp_start, !rdy_n})); // R7

endmodule

// File: rtl/sync_pd_sequencer.sv
module sync_pd_sequencer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DECIM       = 8,
  parameter int unsigned SETTLE_ODR  = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pd_n,
  output logic core_en,
  output logic filt_clr,
  output logic samp_start,
  output logic rdy_n
);

  localparam int unsigned SETTLE_CYCLES = DECIM * SETTLE_ODR;
  localparam int unsigned CNT_W         = $clog2(SETTLE_CYCLES);

  logic pin_lvl;
  logic count_en;
  logic settle_done;

  sync_pd_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sync_pd_n),
    .q_sync  (pin_lvl)
  );

  sync_pd_settle #(
    .LIMIT (SETTLE_CYCLES),
    .CW    (CNT_W)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .done     (settle_done)
  );

  sync_pd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl     (pin_lvl),
    .settle_done (settle_done),
    .count_en    (count_en),
    .core_en     (core_en),
    .filt_clr    (filt_clr),
    .samp_start  (samp_start),
    .rdy_n       (rdy_n)
  );

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_clr) |=> rdy_n); // R7

endmodule

// File: tb/sync_pd_sequencer_tb.sv
module sync_pd_sequencer_tb;

  typedef struct packed {
    logic       pin;
    logic [7:0] hold;
    logic       core;
    logic       fclr;
    logic       samp;
    logic       rdyn;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 23;
  // Settling in the bench build: DECIM=2 * SETTLE_ODR=5 = 10 edges after filt_clr
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd2,  1'b0, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 not yet at edge 2
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 up at edge 3
    '{1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 clear pulse (E)
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 sample marker
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 E+2
    '{1'b1, 8'd7,  1'b1, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 E+9 still invalid
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 E+10 ready
    '{1'b1, 8'd20, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 steady run
    '{1'b0, 8'd2,  1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 not yet
    '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 8'd2},  // R2 powered down
    '{1'b0, 8'd30, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3},  // R3 held low
    '{1'b1, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 wake
    '{1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 (E)
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8'd6},  // R6
    '{1'b1, 8'd4,  1'b1, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 E+5
    '{1'b0, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 pulse low E+6
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 E+7 not seen yet
    '{1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 E+8 powered down
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 E+9 back up
    '{1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 1'b1, 8'd9},  // R9 new clear (E')
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8'd9},  // R9 new sample
    '{1'b1, 8'd8,  1'b1, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 E'+9 still invalid
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b0, 8'd9}   // R9 E'+10 ready
  };

  logic clk;
  logic rst_n;
  logic sync_pd_n;
  logic core_en;
  logic filt_clr;
  logic samp_start;
  logic rdy_n;

  int n_checks;
  int n_fails;
  bit finished;

  sync_pd_sequencer #(
    .SYNC_STAGES (2),
    .DECIM       (2),
    .SETTLE_ODR  (5)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pd_n  (sync_pd_n),
    .core_en    (core_en),
    .filt_clr   (filt_clr),
    .samp_start (samp_start),
    .rdy_n      (rdy_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_outs(input logic ec, input logic ef, input logic es,
                            input logic er, input int req);
    n_checks++;
    if ({core_en, filt_clr, samp_start, rdy_n} !== {ec, ef, es, er}) begin
      n_fails++;
      $display("FAIL R%0d: core/clr/samp/rdy_n actual %b%b%b%b expected %b%b%b%b",
               req, core_en, filt_clr, samp_start, rdy_n, ec, ef, es, er);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    sync_pd_n = 1'b0;
    repeat (3) @(negedge clk);
    check_outs(1'b0, 1'b0, 1'b0, 1'b1, 1);  // R1 during reset
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_outs(1'b0, 1'b0, 1'b0, 1'b1, 1);  // R1 after release, pin low

    for (int i = 0; i < NV; i++) begin
      sync_pd_n = VECS[i].pin;
      repeat (int'(VECS[i].hold)) @(posedge clk);
      @(negedge clk);
      check_outs(VECS[i].core, VECS[i].fclr, VECS[i].samp, VECS[i].rdyn,
                 int'(VECS[i].req));
    end

    // Directed: asynchronous reset while running with valid data (R1)
    #2 rst_n = 1'b0;
    #1 check_outs(1'b0, 1'b0, 1'b0, 1'b1, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // Pin held high: synchroniser restarts from low, wake after two edges (R4)
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_outs(1'b0, 1'b0, 1'b0, 1'b1, 4);
    @(posedge clk);
    @(negedge clk);
    check_outs(1'b1, 1'b0, 1'b0, 1'b1, 4);
    @(posedge clk);
    @(negedge clk);
    check_outs(1'b1, 1'b1, 1'b0, 1'b1, 5);

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      report();
    end
  end

endmodule